// File: doc/BRIEF.md
# I2S Master Playback Serializer

This block drives a stereo I2S link as the clock master and plays out samples from a local transmit FIFO. The system clock is divided by a 5-bit prescaler value n, giving a master clock of clk/(n+1). A frame lasts 384 master clocks, and the bit clock runs at 32 bits per frame. This gives two 16-bit channel slots per frame. Samples can be 16-bit or 8-bit. Both widths use the same slot timing.

A DMA engine outside the block keeps the FIFO filled. The block requests data whenever the FIFO has room and DMA requests are enabled. Software sets the format, the prescaler, transmit enable and DMA enable with one write strobe.

A separate search engine takes a requested frame rate. It tests all 32 prescaler values, one per clock, and reports the value whose frame rate is nearest to the request. The result is given twice, in the layout of a prescaler register that holds two copies.

Top module: `i2s_tx_top`

## Requirements
- R1: With transmit enabled and prescaler value n, the bit clock rises every 12·(n+1) system clocks, because it is 1/12 of the master clock clk/(n+1).
- R2: A frame lasts 384·(n+1) system clocks, which is 32 bit clocks. Word select falls once per frame.
- R3: Framing is I2S. Word select is low for the left slot and high for the right slot. Word select and serial data change only on a falling bit clock edge. Each word is sent MSB first, starting one bit after the word-select edge. One FIFO entry is sent per frame, in push order.
- R4: With format code 2'b00 (16-bit), a FIFO entry carries the left sample in bits [31:16] and the right sample in bits [15:0]. Each sample fills its 16-bit slot.
- R5: With format code 2'b01 (8-bit), bits [23:16] form the left sample and bits [7:0] form the right sample. Each is sent MSB first and followed by eight zero bits. The other entry bits are ignored.
- R6: A configuration write with any other format code is rejected. It pulses `cfg_err_o` for one cycle and leaves the prescaler, format, enables and underrun flag unchanged.
- R7: The FIFO holds 32 entries. A push while the FIFO is full is dropped. `tx_req_o` is high exactly when DMA is enabled and the FIFO is not full.
- R8: If the FIFO is empty when a frame's word is loaded, that frame is sent as zeros and `underrun_o` is set. The flag stays set until the next accepted configuration write.
- R9: The rate search returns the n in 0..31 that minimises |clk/384/(n+1) − rate|. On a tie the smaller n wins. The result appears on `srch_presc_o` as {n, n}.
- R10: `srch_done_o` pulses for one cycle, 32 cycles after the edge that samples `srch_start_i`.
- R11: After reset the bit clock, word select, serial data, request, error, underrun and done outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_fmt_i | input | 2 | Sample format: 00 = 16-bit, 01 = 8-bit, other codes rejected |
| cfg_presc_i | input | 5 | Prescaler value n |
| cfg_tx_en_i | input | 1 | Transmit enable |
| cfg_dma_en_i | input | 1 | Transmit request enable |
| cfg_err_o | output | 1 | One-cycle pulse after a rejected write |
| push_i | input | 1 | FIFO push strobe |
| push_data_i | input | 2·SLOT_W | Stereo entry {left, right} |
| tx_req_o | output | 1 | Transmit data request |
| underrun_o | output | 1 | Sticky underrun flag |
| srch_start_i | input | 1 | Start the rate search |
| srch_rate_i | input | RATE_W | Requested frame rate in Hz |
| srch_done_o | output | 1 | Search complete pulse |
| srch_presc_o | output | 10 | Best prescaler value as {n, n} |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data |

## Verification
The bench builds the block with its default parameters. A 18.432 MHz system clock makes the candidate frame rates 48000/(n+1). This gives every n an exact-match request and creates exact ties, at 36000 and 20000, that test the smaller-n rule. Requested rates are swept across the whole candidate range. A 32-entry FIFO is small enough to fill to overflow and drain to underrun within one run. Prescaler values 0, 1 and 2 are used, which keeps frames short enough to decode many of them sample by sample.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int unsigned PRESC_W = 5;

  typedef enum logic [1:0] {
    FMT_S16 = 2'b00,
    FMT_S8  = 2'b01
  } fmt_e;

  typedef struct packed {
    logic               fmt8;
    logic [PRESC_W-1:0] presc;
    logic               tx_en;
    logic               dma_en;
  } cfg_t;
endpackage

// File: rtl/i2s_rate_search.sv
module i2s_rate_search #(
  parameter int unsigned SYS_HZ  = 18_432_000,
  parameter int unsigned MCLK_FS = 384,
  parameter int unsigned RATE_W  = 20,
  parameter int unsigned PW      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              done_o,
  output logic [2*PW-1:0]   presc_o
);
  localparam int unsigned NCAND = 1 << PW;

  logic [RATE_W-1:0] cand [NCAND];

  for (genvar g = 0; g < NCAND; g++) begin : g_cand
    localparam logic [RATE_W-1:0] CRATE = RATE_W'(SYS_HZ / MCLK_FS / (g + 1));
    assign cand[g] = CRATE;
  end

  logic              busy_q, done_q;
  logic [PW-1:0]     idx_q, best_q, res_q;
  logic [RATE_W-1:0] rate_q, bdiff_q, cur_w, diff_w;
  logic              better_w;

  assign cur_w    = cand[idx_q];
  assign diff_w   = (cur_w > rate_q) ? cur_w - rate_q : rate_q - cur_w;
  assign better_w = diff_w < bdiff_q;  // strict: earliest n keeps a tie

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      best_q  <= '0;
      res_q   <= '0;
      rate_q  <= '0;
      bdiff_q <= '1;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      idx_q   <= '0;
      best_q  <= '0;
      rate_q  <= rate_i;
      bdiff_q <= '1;
    end else if (busy_q) begin
      idx_q <= idx_q + 1'b1;
      if (better_w) begin
        best_q  <= idx_q;
        bdiff_q <= diff_w;
      end
      if (idx_q == PW'(NCAND - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        res_q  <= better_w ? idx_q : best_q;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o  = done_q;
  assign presc_o = {res_q, res_q};

  p_done_after_scan_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(busy_q) && $past(idx_q) == PW'(NCAND - 1));
  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/i2s_txfifo.sv
module i2s_txfifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          wr_w, rd_w;

  assign empty_o = cnt_q == '0;
  assign full_o  = cnt_q == CW'(DEPTH);
  assign wr_w    = push_i && !full_o;
  assign rd_w    = pop_i && !empty_o;
  assign data_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (wr_w) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_w) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (rd_w) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(wr_w) - CW'(rd_w);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(cnt_q));
  p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> $stable(cnt_q));
endmodule

// File: rtl/i2s_tx_core.sv
module i2s_tx_core #(
  parameter int unsigned SLOT_W   = 16,
  parameter int unsigned HALF_DIV = 6,
  parameter int unsigned PW       = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [PW-1:0]       presc_i,
  input  logic                fmt8_i,
  input  logic                empty_i,
  input  logic [2*SLOT_W-1:0] data_i,
  input  logic                urun_clr_i,
  output logic                pop_o,
  output logic                urun_o,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sd_o
);
  localparam int unsigned WW  = 2 * SLOT_W;
  localparam int unsigned SLW = $clog2(WW);
  localparam int unsigned HW  = $clog2(HALF_DIV);

  logic [PW-1:0]  pcnt_q;
  logic [HW-1:0]  hcnt_q;
  logic [SLW-1:0] slot_q, slot_nx;
  logic [WW-1:0]  sh_q, word_w;
  logic           bclk_q, ws_q, sd_q, urun_q;
  logic           mtick_w, edge_w, fall_w, load_w;

  assign mtick_w = run_i && (pcnt_q == presc_i);
  assign edge_w  = mtick_w && (hcnt_q == HW'(HALF_DIV - 1));
  assign fall_w  = edge_w && bclk_q;
  assign slot_nx = slot_q + 1'b1;
  assign load_w  = fall_w && (slot_nx == SLW'(1));
  assign pop_o   = load_w && !empty_i;

  always_comb begin
    if (empty_i)     word_w = '0;
    else if (fmt8_i) word_w = {data_i[SLOT_W+7:SLOT_W], {(SLOT_W-8){1'b0}},
                               data_i[7:0], {(SLOT_W-8){1'b0}}};
    else             word_w = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0; hcnt_q <= '0; slot_q <= '0; sh_q <= '0;
      bclk_q <= 1'b0; ws_q <= 1'b0; sd_q <= 1'b0;
    end else if (!run_i) begin
      pcnt_q <= '0; hcnt_q <= '0; slot_q <= '0; sh_q <= '0;
      bclk_q <= 1'b0; ws_q <= 1'b0; sd_q <= 1'b0;
    end else begin
      pcnt_q <= mtick_w ? '0 : pcnt_q + 1'b1;
      if (mtick_w) hcnt_q <= (hcnt_q == HW'(HALF_DIV - 1)) ? '0 : hcnt_q + 1'b1;
      if (edge_w) bclk_q <= ~bclk_q;
      if (fall_w) begin
        slot_q <= slot_nx;
        ws_q   <= slot_nx[SLW-1];
        if (load_w) begin
          sd_q <= word_w[WW-1];
          sh_q <= {word_w[WW-2:0], 1'b0};
        end else begin
          sd_q <= sh_q[WW-1];
          sh_q <= {sh_q[WW-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                urun_q <= 1'b0;
    else if (urun_clr_i)        urun_q <= 1'b0;
    else if (load_w && empty_i) urun_q <= 1'b1;
  end

  assign bclk_o = bclk_q;
  assign ws_o   = ws_q;
  assign sd_o   = sd_q;
  assign urun_o = urun_q;

  p_ws_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$stable(ws_q)) |-> $fell(bclk_q));
  p_sd_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$stable(sd_q)) |-> $fell(bclk_q));
endmodule

// File: rtl/i2s_tx_top.sv
module i2s_tx_top
  import i2s_tx_pkg::*;
#(
  parameter int unsigned SYS_HZ     = 18_432_000,
  parameter int unsigned RATE_W     = 20,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned MCLK_FS    = 384,
  parameter int unsigned SLOT_W     = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_fmt_i,
  input  logic [PRESC_W-1:0]  cfg_presc_i,
  input  logic                cfg_tx_en_i,
  input  logic                cfg_dma_en_i,
  output logic                cfg_err_o,
  input  logic                push_i,
  input  logic [2*SLOT_W-1:0] push_data_i,
  output logic                tx_req_o,
  output logic                underrun_o,
  input  logic                srch_start_i,
  input  logic [RATE_W-1:0]   srch_rate_i,
  output logic                srch_done_o,
  output logic [2*PRESC_W-1:0] srch_presc_o,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sd_o
);
  localparam int unsigned BCLK_FS  = 2 * SLOT_W;
  localparam int unsigned HALF_DIV = MCLK_FS / (2 * BCLK_FS);

  cfg_t cfg_q;
  logic err_q, fmt_ok_w, accept_w;
  logic pop_w, empty_w, full_w;
  logic [2*SLOT_W-1:0] fifo_dout_w;

  assign fmt_ok_w = (cfg_fmt_i == FMT_S16) || (cfg_fmt_i == FMT_S8);
  assign accept_w = cfg_we_i && fmt_ok_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= cfg_we_i && !fmt_ok_w;
      if (accept_w) begin
        cfg_q.fmt8   <= cfg_fmt_i == FMT_S8;
        cfg_q.presc  <= cfg_presc_i;
        cfg_q.tx_en  <= cfg_tx_en_i;
        cfg_q.dma_en <= cfg_dma_en_i;
      end
    end
  end

  assign cfg_err_o = err_q;
  assign tx_req_o  = cfg_q.dma_en && !full_w;

  i2s_txfifo #(.DW(2 * SLOT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .data_i  (push_data_i),
    .pop_i   (pop_w),
    .data_o  (fifo_dout_w),
    .empty_o (empty_w),
    .full_o  (full_w)
  );

  i2s_tx_core #(.SLOT_W(SLOT_W), .HALF_DIV(HALF_DIV), .PW(PRESC_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (cfg_q.tx_en),
    .presc_i    (cfg_q.presc),
    .fmt8_i     (cfg_q.fmt8),
    .empty_i    (empty_w),
    .data_i     (fifo_dout_w),
    .urun_clr_i (accept_w),
    .pop_o      (pop_w),
    .urun_o     (underrun_o),
    .bclk_o     (bclk_o),
    .ws_o       (ws_o),
    .sd_o       (sd_o)
  );

  i2s_rate_search #(.SYS_HZ(SYS_HZ), .MCLK_FS(MCLK_FS), .RATE_W(RATE_W), .PW(PRESC_W)) u_search (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (srch_start_i),
    .rate_i  (srch_rate_i),
    .done_o  (srch_done_o),
    .presc_o (srch_presc_o)
  );

  p_bad_fmt_keeps_cfg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !fmt_ok_w) |=> $stable(cfg_q) && cfg_err_o);
  p_req_off_when_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_w |-> !tx_req_o);
  p_pop_nonempty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_w |-> !empty_w);
endmodule

// File: tb/i2s_tx_top_test.sv
`timescale 1ns/1ps
module i2s_tx_top_test;
  localparam int SYS_HZ = 18_432_000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_tx = 0, cfg_dma = 0, push = 0, s_start = 0;
  logic [1:0] cfg_fmt = 0;
  logic [4:0] cfg_presc = 0;
  logic [31:0] push_data = 0;
  logic [19:0] s_rate = 0;
  logic cfg_err, tx_req, urun, s_done, bclk, ws, sd;
  logic [9:0] s_presc;

  always #2 clk = ~clk;

  i2s_tx_top uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_fmt_i(cfg_fmt),
    .cfg_presc_i(cfg_presc), .cfg_tx_en_i(cfg_tx), .cfg_dma_en_i(cfg_dma),
    .cfg_err_o(cfg_err), .push_i(push), .push_data_i(push_data), .tx_req_o(tx_req),
    .underrun_o(urun), .srch_start_i(s_start), .srch_rate_i(s_rate),
    .srch_done_o(s_done), .srch_presc_o(s_presc), .bclk_o(bclk), .ws_o(ws), .sd_o(sd));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // line monitor
  int cyc = 0, last_rise = -1, last_fall = -1;
  int per_min, per_max, frm_min, frm_max, nrx;
  logic bclk_p = 0, ws_p = 0, ws_pr = 0;
  logic [15:0] sr = 0, l_pend = 0;
  logic [15:0] rx_l [64];
  logic [15:0] rx_r [64];

  task automatic mon_reset();
    last_rise = -1; last_fall = -1; nrx = 0;
    per_min = 1 << 30; per_max = 0; frm_min = 1 << 30; frm_max = 0;
    ws_pr = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (bclk && !bclk_p) begin
      if (last_rise >= 0) begin
        if (cyc - last_rise < per_min) per_min = cyc - last_rise;
        if (cyc - last_rise > per_max) per_max = cyc - last_rise;
      end
      last_rise = cyc;
      sr = {sr[14:0], sd};
      if (ws != ws_pr) begin
        if (ws) l_pend = sr;
        else if (nrx < 64) begin
          rx_l[nrx] = l_pend; rx_r[nrx] = sr; nrx++;
        end
      end
      ws_pr = ws;
    end
    if (!ws && ws_p) begin
      if (last_fall >= 0) begin
        if (cyc - last_fall < frm_min) frm_min = cyc - last_fall;
        if (cyc - last_fall > frm_max) frm_max = cyc - last_fall;
      end
      last_fall = cyc;
    end
    bclk_p = bclk; ws_p = ws;
  end

  task automatic cfg_write(input logic [1:0] f, input int n, input bit t, input bit d);
    @(negedge clk);
    cfg_we = 1; cfg_fmt = f; cfg_presc = 5'(n); cfg_tx = t; cfg_dma = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk); push = 1; push_data = w;
    @(negedge clk); push = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_n(input int r);
    int best = 0, bd = 1 << 30;
    for (int i = 0; i < 32; i++) begin
      int c = SYS_HZ / 384 / (i + 1);
      int d = (c > r) ? c - r : r - c;
      if (d < bd) begin bd = d; best = i; end
    end
    return best;
  endfunction

  task automatic search(input int r);
    int c = 0, e;
    @(negedge clk); s_start = 1; s_rate = 20'(r);
    @(negedge clk); s_start = 0;
    while (!s_done && c < 100) begin @(negedge clk); c++; end
    e = exp_n(r);
    chk(c == 32, "R10 done latency", c, 32);
    chk(s_presc == {5'(e), 5'(e)}, "R9 nearest prescaler", s_presc, {5'(e), 5'(e)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d16 [4];
    logic [31:0] d8 [3];
    mon_reset();
    wait_cyc(3);
    // R11 reset state
    chk({bclk, ws, sd, tx_req, cfg_err, urun, s_done} == 7'b0, "R11 reset outputs",
        {bclk, ws, sd, tx_req, cfg_err, urun, s_done}, 0);
    rst_n = 1;
    wait_cyc(2);

    // R9 / R10: rate search sweep, exact candidates and ties
    for (int i = 0; i < 32; i++) search(48000 / (i + 1));
    search(36000); chk(s_presc == 10'h000, "R9 tie picks smaller n", s_presc, 0);
    search(20000); chk(s_presc == {5'd1, 5'd1}, "R9 tie picks smaller n", s_presc, {5'd1, 5'd1});
    for (int r = 0; r < 60000; r += 613) search(r);
    @(negedge clk);
    chk(!s_done, "R10 done one cycle", s_done, 0);

    // R7: request logic and overflow
    cfg_write(2'b00, 0, 0, 0);
    chk(!tx_req, "R7 req off with dma disabled", tx_req, 0);
    cfg_write(2'b00, 0, 0, 1);
    chk(tx_req, "R7 req on with room", tx_req, 1);
    for (int i = 0; i < 31; i++) push_word({16'h1000 + 16'(i), 16'hF000 - 16'(i)});
    chk(tx_req, "R7 req with one slot left", tx_req, 1);
    push_word({16'h1000 + 16'd31, 16'hF000 - 16'd31});
    chk(!tx_req, "R7 req off when full", tx_req, 0);
    push_word(32'hDEAD_BEEF);
    mon_reset();
    cfg_write(2'b00, 0, 1, 1);
    wait_cyc(2 * 384);
    chk(tx_req, "R7 req back after pop", tx_req, 1);
    wait_cyc(32 * 384 + 100);
    chk(nrx >= 33, "R7 frames decoded", nrx, 33);
    for (int i = 0; i < 32; i++)
      chk({rx_l[i], rx_r[i]} == {16'h1000 + 16'(i), 16'hF000 - 16'(i)}, "R7 fifo order",
          {rx_l[i], rx_r[i]}, {16'h1000 + 16'(i), 16'hF000 - 16'(i)});
    chk({rx_l[32], rx_r[32]} == 0, "R7 overflow push dropped", {rx_l[32], rx_r[32]}, 0);
    chk(urun, "R8 underrun after drain", urun, 1);
    cfg_write(2'b00, 0, 0, 0);
    chk(!urun, "R8 cleared by accepted write", urun, 0);

    // R1-R4, R8: 16-bit, n=0
    d16[0] = 32'h8001_7FFE; d16[1] = 32'hA5A5_5A5A; d16[2] = 32'h0001_8000; d16[3] = 32'hFFFF_1234;
    for (int i = 0; i < 4; i++) push_word(d16[i]);
    mon_reset();
    cfg_write(2'b00, 0, 1, 0);
    wait_cyc(3 * 384 + 100);
    chk(!urun, "R8 no underrun with data", urun, 0);
    wait_cyc(3 * 384);
    chk(per_min == 12 && per_max == 12, "R1 bit period n=0", per_max, 12);
    chk(frm_min == 384 && frm_max == 384, "R2 frame n=0", frm_max, 384);
    for (int i = 0; i < 4; i++)
      chk({rx_l[i], rx_r[i]} == d16[i], "R4 R3 16-bit words", {rx_l[i], rx_r[i]}, d16[i]);
    chk({rx_l[4], rx_r[4]} == 0, "R8 zeros on underrun", {rx_l[4], rx_r[4]}, 0);
    chk(urun, "R8 underrun set", urun, 1);
    cfg_write(2'b00, 0, 0, 0);

    // R5: 8-bit, n=2
    d8[0] = 32'hA5C3_5A3C; d8[1] = 32'h0081_FF01; d8[2] = 32'hFF7E_00E7;
    for (int i = 0; i < 3; i++) push_word(d8[i]);
    mon_reset();
    cfg_write(2'b01, 2, 1, 0);
    wait_cyc(4 * 1152 + 200);
    chk(per_min == 36 && per_max == 36, "R1 bit period n=2", per_max, 36);
    chk(frm_min == 1152 && frm_max == 1152, "R2 frame n=2", frm_max, 1152);
    for (int i = 0; i < 3; i++)
      chk({rx_l[i], rx_r[i]} == {d8[i][23:16], 8'h00, d8[i][7:0], 8'h00}, "R5 8-bit words",
          {rx_l[i], rx_r[i]}, {d8[i][23:16], 8'h00, d8[i][7:0], 8'h00});
    chk({rx_l[3], rx_r[3]} == 0, "R8 zeros in 8-bit", {rx_l[3], rx_r[3]}, 0);
    cfg_write(2'b00, 0, 0, 0);

    // R6: rejected format keeps running config, n=1
    cfg_write(2'b00, 1, 1, 0);
    wait_cyc(100);
    cfg_write(2'b10, 0, 0, 1);
    chk(cfg_err, "R6 error pulse", cfg_err, 1);
    @(negedge clk);
    chk(!cfg_err, "R6 error one cycle", cfg_err, 0);
    chk(!tx_req, "R6 dma enable not taken", tx_req, 0);
    cfg_write(2'b11, 3, 1, 0);
    mon_reset();
    wait_cyc(4 * 768);
    chk(per_min == 24 && per_max == 24, "R6 R1 prescaler kept n=1", per_max, 24);
    chk(frm_min == 768 && frm_max == 768, "R6 R2 frame kept n=1", frm_max, 768);
    chk(nrx >= 3, "R6 transmit still enabled", nrx, 3);
    chk(urun, "R6 underrun not cleared", urun, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule